// File: doc/BRIEF.md
# MSI coalescing unit

This block terminates message-signalled interrupt writes. Each legal write on the write port names one of 128 pending registers through its address and one bit inside that register through the low bits of its data. The bit is recorded as pending. The 2048 pending bits are arranged as 16 groups of 8 registers, and each register is 16 bits wide. Each group drives one level interrupt output, so all 2048 vectors reach the interrupt controller on 16 lines.

A service routine reads the summary word of the group that raised its line. It then reads each flagged pending register and handles the set bits from lowest to highest. A read of a pending register returns its contents and clears the bits it returned. Summary reads have no side effect. A malformed write is dropped, and the block raises a one-cycle error flag for it.

Top module: `msi_coalesce`

## Requirements
- R1: After reset, irqOut, wrErr and rdData are zero, and every pending and summary read returns zero.
- R2: A write to byte address ((g*8 + x) << 16), with the low 16 address bits zero and data d in 0..15, sets bit d of pending register x of group g. All other pending bits keep their values.
- R3: Vector v is reached by writing data (v/16) mod 16 to register v/256 of group v mod 16. A later read of that register returns exactly that one bit.
- R4: A read of a pending register returns its value on rdData in the cycle after rdEn. Exactly the returned bits are cleared.
- R5: When a write and a read of the same pending register fall in the same cycle, the written bit is still pending afterwards. The read returns the register value from before the write.
- R6: Reading address 0x800000 + (g << 16) returns a word whose bit x is 1 exactly when register x of group g is non-zero. This read clears nothing.
- R7: irqOut[g] rises one cycle after the cycle in which group g first holds a pending bit. It falls one cycle after its last pending bit is cleared.
- R8: A write whose data exceeds 15, or whose address is outside both the pending range and the summary range, changes no state. wrErr is 1 for exactly the one cycle after that write.
- R9: A write to a summary address changes no state and leaves wrErr at 0.
- R10: rdData holds its value while rdEn is low. A read of an undecoded address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one message |
| wrAddr | input | 24 | Byte address of the write |
| wrData | input | 32 | Write data; bits 3:0 select the pending bit |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 24 | Byte address of the read |
| rdData | output | 32 | Read result, valid the cycle after rdEn |
| wrErr | output | 1 | One-cycle pulse for a dropped write |
| irqOut | output | 16 | Level interrupt line for each group |

## Verification
The two functions that can land on one pending register in the same cycle are the clear-on-read and the bit-set from a new message. The bench drives both ports on the same clock. It does this once with the write aimed at a different bit from the one already pending, and once with the write aimed at the same bit. It judges the result from the value the read returns and from a second read that must still show the newly written bit. A full sweep over all 2048 vectors checks the address and data mapping, the summary word and the timing of the interrupt lines.

// File: rtl/msi_coalesce_pkg.sv
package msi_coalesce_pkg;
  localparam int NUM_GROUPS    = 16;
  localparam int IDX_PER_GROUP = 8;
  localparam int BITS_PER_IDX  = 16;
  localparam int REG_SHIFT     = 16;
  localparam int DATA_W        = 32;

  localparam int GRP_W   = $clog2(NUM_GROUPS);
  localparam int IDX_W   = $clog2(IDX_PER_GROUP);
  localparam int BIT_W   = $clog2(BITS_PER_IDX);
  localparam int SUM_SEL = REG_SHIFT + IDX_W + GRP_W;
  localparam int ADDR_W  = SUM_SEL + 1;

  typedef struct packed {
    logic             setEn;
    logic [GRP_W-1:0] setGrp;
    logic [IDX_W-1:0] setIdx;
    logic [BIT_W-1:0] setBit;
    logic             clrEn;
    logic             sumRd;
    logic [GRP_W-1:0] rdGrp;
    logic [IDX_W-1:0] rdIdx;
    logic             rdCapture;
    logic             wrErr;
  } strobe_t;
endpackage

// File: rtl/msi_coalesce_ctrl.sv
module msi_coalesce_ctrl
  import msi_coalesce_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           st
);
  logic wrLowZero, wrIsIdx, wrIsSum, wrDataOk;
  logic rdLowZero, rdIsIdx, rdIsSum;

  always_comb begin
    wrLowZero = (wrAddr[REG_SHIFT-1:0] == '0);
    wrIsIdx   = !wrAddr[SUM_SEL] && wrLowZero;
    wrIsSum   = wrAddr[SUM_SEL] && wrLowZero &&
                (wrAddr[SUM_SEL-1:REG_SHIFT+GRP_W] == '0);
    wrDataOk  = (wrData[DATA_W-1:BIT_W] == '0);

    rdLowZero = (rdAddr[REG_SHIFT-1:0] == '0);
    rdIsIdx   = !rdAddr[SUM_SEL] && rdLowZero;
    rdIsSum   = rdAddr[SUM_SEL] && rdLowZero &&
                (rdAddr[SUM_SEL-1:REG_SHIFT+GRP_W] == '0);

    st.setEn  = wrEn && wrIsIdx && wrDataOk;
    st.setGrp = wrAddr[REG_SHIFT+IDX_W +: GRP_W];
    st.setIdx = wrAddr[REG_SHIFT +: IDX_W];
    st.setBit = wrData[BIT_W-1:0];
    st.wrErr  = wrEn && !wrIsSum && !(wrIsIdx && wrDataOk);

    st.clrEn     = rdEn && rdIsIdx;
    st.sumRd     = rdEn && rdIsSum;
    st.rdGrp     = rdIsSum ? rdAddr[REG_SHIFT +: GRP_W]
                           : rdAddr[REG_SHIFT+IDX_W +: GRP_W];
    st.rdIdx     = rdAddr[REG_SHIFT +: IDX_W];
    st.rdCapture = rdEn;
  end
endmodule

// File: rtl/msi_coalesce_dp.sv
module msi_coalesce_dp
  import msi_coalesce_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  output logic [DATA_W-1:0]     rdData,
  output logic                  wrErr,
  output logic [NUM_GROUPS-1:0] irqOut
);
  logic [BITS_PER_IDX-1:0]  pend     [NUM_GROUPS][IDX_PER_GROUP];
  logic [BITS_PER_IDX-1:0]  pendNext [NUM_GROUPS][IDX_PER_GROUP];
  logic [IDX_PER_GROUP-1:0] summ     [NUM_GROUPS];
  logic [NUM_GROUPS-1:0]    groupAny;
  logic [DATA_W-1:0]        rdNext;

  // Clear from a read first, then the set from a write, so a new event survives.
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int i = 0; i < IDX_PER_GROUP; i++) begin
        pendNext[g][i] = pend[g][i];
        if (st.clrEn && st.rdGrp == GRP_W'(g) && st.rdIdx == IDX_W'(i))
          pendNext[g][i] = '0;
        if (st.setEn && st.setGrp == GRP_W'(g) && st.setIdx == IDX_W'(i))
          pendNext[g][i][st.setBit] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int i = 0; i < IDX_PER_GROUP; i++)
          pend[g][i] <= '0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int i = 0; i < IDX_PER_GROUP; i++)
          pend[g][i] <= pendNext[g][i];
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int i = 0; i < IDX_PER_GROUP; i++)
        summ[g][i] = |pend[g][i];
      groupAny[g] = |summ[g];
    end
  end

  always_comb begin
    rdNext = '0;
    if (st.clrEn)
      rdNext = DATA_W'(pend[st.rdGrp][st.rdIdx]);
    else if (st.sumRd)
      rdNext = DATA_W'(summ[st.rdGrp]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      wrErr  <= 1'b0;
      irqOut <= '0;
    end else begin
      if (st.rdCapture) rdData <= rdNext;
      wrErr  <= st.wrErr;
      irqOut <= groupAny;
    end
  end
endmodule

// File: rtl/msi_coalesce.sv
module msi_coalesce
  import msi_coalesce_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  wrErr,
  output logic [NUM_GROUPS-1:0] irqOut
);
  strobe_t st;

  msi_coalesce_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .st(st)
  );

  msi_coalesce_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .rdData(rdData), .wrErr(wrErr), .irqOut(irqOut)
  );
endmodule

// File: rtl/msi_coalesce_checker.sv
module msi_coalesce_checker
  import msi_coalesce_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [DATA_W-1:0]     wrData,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic [DATA_W-1:0]     rdData,
  input logic                  wrErr,
  input logic [NUM_GROUPS-1:0] irqOut
);
  logic [1:0] sinceRst;
  logic       cIdx, cSum, cBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign cIdx = (wrAddr[ADDR_W-1] == 1'b0) && (wrAddr[REG_SHIFT-1:0] == '0);
  assign cSum = wrAddr[ADDR_W-1] && (wrAddr[REG_SHIFT-1:0] == '0) &&
                (wrAddr[ADDR_W-2:REG_SHIFT+GRP_W] == '0);
  assign cBad = (wrData > DATA_W'(BITS_PER_IDX - 1));

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (irqOut == '0 && wrErr == 1'b0 && rdData == '0));

  // R8
  a_r8_err_only_for_bad_write: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn && ((cIdx && cBad) || (!cIdx && !cSum))));

  // R9
  a_r9_summary_write_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cSum) |=> !wrErr);

  // R10
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R7
  a_r7_irq_needs_activity: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && !$past(wrEn, 2) && !$past(rdEn, 2)) |-> $stable(irqOut));
endmodule

bind msi_coalesce msi_coalesce_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .wrErr(wrErr), .irqOut(irqOut)
);

// File: tb/msi_coalesce_bench.sv
module msi_coalesce_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [23:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [23:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        wrErr;
  logic [15:0] irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_coalesce u_msi_coalesce (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .wrErr(wrErr), .irqOut(irqOut)
  );

  function automatic logic [23:0] idxAddr(int g, int x);
    return 24'((g * 8 + x) << 16);
  endfunction

  function automatic logic [23:0] sumAddr(int g);
    return 24'(32'h800000 + (g << 16));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doWrite(logic [23:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [23:0] a);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doBoth(logic [23:0] wa, logic [31:0] wd, logic [23:0] ra);
    wrEn = 1'b1; wrAddr = wa; wrData = wd;
    rdEn = 1'b1; rdAddr = ra;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 irqOut", 32'(irqOut), 32'h0);
    check("R1 wrErr", 32'(wrErr), 32'h0);
    check("R1 rdData", rdData, 32'h0);
    doRead(sumAddr(5));
    check("R1 summary", rdData, 32'h0);
    doRead(idxAddr(9, 3));
    check("R1 pending", rdData, 32'h0);

    // R2 R3 R6 R7 sweep of every vector
    for (int v = 0; v < 2048; v++) begin
      int g = v % 16;
      int b = (v / 16) % 16;
      int x = v / 256;
      doWrite(idxAddr(g, x), 32'(b));
      check("R2 no error", 32'(wrErr), 32'h0);
      step();
      check("R7 irq rise", 32'(irqOut), 32'(1 << g));
      doRead(sumAddr(g));
      check("R6 summary", rdData, 32'(1 << x));
      doRead(idxAddr(g, x));
      check("R3 vector bit", rdData, 32'(1 << b));
      step();
      check("R7 irq fall", 32'(irqOut), 32'h0);
    end

    // R2 R4 R6 several bits in one register
    doWrite(idxAddr(3, 6), 32'd1);
    doWrite(idxAddr(3, 6), 32'd7);
    doWrite(idxAddr(3, 6), 32'd15);
    doRead(sumAddr(3));
    check("R6 summary", rdData, 32'h40);
    doRead(sumAddr(3));
    check("R6 summary not cleared", rdData, 32'h40);
    doRead(idxAddr(3, 6));
    check("R4 multi-bit read", rdData, 32'h8082);
    doRead(idxAddr(3, 6));
    check("R4 cleared after read", rdData, 32'h0);

    // R5 read and write of the same register in one cycle, different bit
    doWrite(idxAddr(2, 1), 32'd3);
    doBoth(idxAddr(2, 1), 32'd5, idxAddr(2, 1));
    check("R5 old value returned", rdData, 32'h0008);
    doRead(idxAddr(2, 1));
    check("R5 new bit kept", rdData, 32'h0020);
    // R5 same bit
    doWrite(idxAddr(2, 1), 32'd3);
    doBoth(idxAddr(2, 1), 32'd3, idxAddr(2, 1));
    check("R5 same-bit read", rdData, 32'h0008);
    doRead(idxAddr(2, 1));
    check("R5 same-bit kept", rdData, 32'h0008);
    step();
    step();
    check("R7 idle after drain", 32'(irqOut), 32'h0);

    // R8 dropped writes
    doWrite(idxAddr(4, 0), 32'd16);
    check("R8 bad data err", 32'(wrErr), 32'h1);
    step();
    check("R8 err pulse one cycle", 32'(wrErr), 32'h0);
    check("R8 no irq", 32'(irqOut), 32'h0);
    doRead(idxAddr(4, 0));
    check("R8 bad data dropped", rdData, 32'h0);
    doWrite(idxAddr(4, 0) + 24'd4, 32'd1);
    check("R8 unaligned err", 32'(wrErr), 32'h1);
    doRead(idxAddr(4, 0));
    check("R8 unaligned dropped", rdData, 32'h0);
    doWrite(24'hA00000, 32'd0);
    check("R8 undecoded err", 32'(wrErr), 32'h1);
    step();
    check("R8 undecoded no irq", 32'(irqOut), 32'h0);

    // R9 summary writes ignored
    doWrite(sumAddr(4), 32'd3);
    check("R9 no err", 32'(wrErr), 32'h0);
    step();
    check("R9 no irq", 32'(irqOut), 32'h0);
    doRead(sumAddr(4));
    check("R9 summary unchanged", rdData, 32'h0);

    // R10 hold and undecoded read
    doWrite(idxAddr(0, 0), 32'd9);
    doRead(idxAddr(0, 0));
    check("R10 read value", rdData, 32'h200);
    step();
    step();
    check("R10 hold", rdData, 32'h200);
    doRead(24'hA00000);
    check("R10 undecoded read", rdData, 32'h0);

    finish();
  end
endmodule